// File: doc/BRIEF.md
# Single-Wire Serial Slave Link

This block is the device end of a half-duplex serial link that shares one open-drain wire with a host. Each transaction opens with a long low pulse from the host, which marks a frame boundary. A command byte follows. Its top bit chooses between writing and reading, and its lower seven bits pick one of 128 register locations. A write carries one more byte from the host, and the block hands that byte to a register-file write port as a single-cycle strobe. A read makes the block fetch the addressed byte through a read strobe, wait a fixed response delay, and then send the byte back on the same wire.

Bits are carried by how long the wire stays low. The block synchronises the wire with two flops and restarts a sample timer on every falling edge. It samples the wire a fixed number of clocks later: a wire already released at that point reads as 1, and a wire still low reads as 0. On transmit, the block only ever pulls the wire low, for a short time to send a 1 and a long time to send a 0, inside a fixed bit cell. A low pulse longer than the break threshold cancels whatever is in progress and starts a new frame.

Top module: `sw_link_slave`

## Requirements
- R1: A low level lasting at least BREAK_MIN clocks at the synchronised input is a break and opens a frame. Bits that arrive before the first break after reset produce no strobe and no response.
- R2: Bytes are received least significant bit first. In the command byte, bit 7 set to 1 means write and 0 means read, and bits 6..0 are the register address presented on `reg_addr`.
- R3: A received bit is 1 if the wire is high SAMPLE_AT clocks after its synchronised falling edge, and 0 if it is still low.
- R4: After the eighth data bit of a write, `reg_wr_en` is high for exactly one cycle, with `reg_addr` and `reg_wr_data` holding the command address and the received byte during that cycle.
- R5: After a read command, `reg_rd_en` is high for exactly one cycle with `reg_addr` valid, and `reg_rd_data` is captured in that cycle.
- R6: The response byte goes out least significant bit first, one bit per BIT_CELL clocks. A 1 pulls the wire low for TX_LOW_ONE clocks and a 0 for TX_LOW_ZERO clocks. The output only ever requests a low level, and it does so only while a response is being sent.
- R7: The first response pulse begins no earlier than SAMPLE_AT+RESP_DELAY clocks and no later than SAMPLE_AT+RESP_DELAY+8 clocks after the falling edge of the last command bit.
- R8: A break received during any phase, including a response in progress, releases the wire at once and leaves the link ready for a new command.
- R9: A frame carries one transaction. After a write or a read completes, further bits produce no strobe and no response until the next break.
- R10: After reset the wire is released and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Level of the shared wire, asynchronous |
| line_pull_low | output | 1 | 1 enables the open-drain pull-down on the wire |
| reg_addr | output | 7 | Register address from the command byte |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_data | output | 8 | Byte to write, valid with `reg_wr_en` |
| reg_rd_en | output | 1 | One-cycle register read strobe |
| reg_rd_data | input | 8 | Register byte, sampled while `reg_rd_en` is high |

## Verification
The bench checks the command flag and address at their extreme values (0x00 and 0x7F, all-zero and all-ones data). A design that shifted in the wrong order or decoded the flag from bit 0 would strobe the wrong address or turn a read into a write. The bench measures each response pulse width, the spacing between response cells and the delay before the first cell. Swapped widths or a wrong bit order show up as a different byte, and a design that started the reply too early would collide with the host's last bit. The bench also sends bytes with no break before them and in a frame that has already finished, where a lax frame tracker would issue stray strobes. Finally it breaks into a live response, where a design that did not abort would keep pulling the wire down.

// File: rtl/sw_link_pkg.sv
package sw_link_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_RDREQ,
    ST_TX
  } link_state_e;

  typedef enum logic [1:0] {
    TX_OFF,
    TX_WAIT,
    TX_SEND
  } tx_phase_e;

  // received bits enter at the top, so the first bit ends up in bit 0
  function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] sh, input logic b);
    return {b, sh[BYTE_W-1:1]};
  endfunction

  function automatic logic cmd_is_write(input logic [BYTE_W-1:0] c);
    return c[BYTE_W-1];
  endfunction

  function automatic logic [ADDR_W-1:0] cmd_addr(input logic [BYTE_W-1:0] c);
    return c[ADDR_W-1:0];
  endfunction
endpackage

// File: rtl/sw_line_sync.sv
module sw_line_sync #(
  parameter int BREAK_MIN = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_s,
  output logic fall,
  output logic brk_evt
);
  localparam int RW = $clog2(BREAK_MIN + 1);

  logic s1, s2, prev;
  logic [RW-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1      <= 1'b1;
      s2      <= 1'b1;
      prev    <= 1'b1;
      low_run <= '0;
      brk_evt <= 1'b0;
    end else begin
      s1      <= line_in;
      s2      <= s1;
      prev    <= s2;
      brk_evt <= 1'b0;
      if (s2) begin
        low_run <= '0;
      end else if (low_run != RW'(BREAK_MIN)) begin
        low_run <= low_run + RW'(1);
        if (low_run == RW'(BREAK_MIN - 1)) brk_evt <= 1'b1;
      end
    end
  end

  assign line_s = s2;
  assign fall   = prev & ~s2;
endmodule

// File: rtl/sw_bit_rx.sv
module sw_bit_rx #(
  parameter int SAMPLE_AT = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_s,
  input  logic fall,
  output logic bit_stb,
  output logic bit_val
);
  localparam int CW = $clog2(SAMPLE_AT + 1);

  logic          meas;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meas    <= 1'b0;
      cnt     <= '0;
      bit_stb <= 1'b0;
      bit_val <= 1'b0;
    end else begin
      bit_stb <= 1'b0;
      if (fall) begin
        meas <= 1'b1;
        cnt  <= '0;
      end else if (meas) begin
        if (cnt == CW'(SAMPLE_AT - 1)) begin
          bit_stb <= 1'b1;
          bit_val <= line_s;
          meas    <= 1'b0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sw_bit_tx.sv
module sw_bit_tx
  import sw_link_pkg::*;
#(
  parameter int RESP_DELAY = 40,
  parameter int BIT_CELL   = 50,
  parameter int LOW_ONE    = 8,
  parameter int LOW_ZERO   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              pull_low,
  output logic              busy
);
  localparam int MAXC = (RESP_DELAY > BIT_CELL) ? RESP_DELAY : BIT_CELL;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int IW   = $clog2(BYTE_W);

  tx_phase_e         phase;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic [BYTE_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= TX_OFF;
      cnt   <= '0;
      idx   <= '0;
      sh    <= '0;
    end else if (abort) begin
      phase <= TX_OFF;
      cnt   <= '0;
    end else if (start) begin
      phase <= TX_WAIT;
      cnt   <= '0;
      idx   <= '0;
      sh    <= byte_in;
    end else begin
      case (phase)
        TX_WAIT: begin
          if (cnt == CW'(RESP_DELAY - 1)) begin
            phase <= TX_SEND;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        TX_SEND: begin
          if (cnt == CW'(BIT_CELL - 1)) begin
            cnt <= '0;
            sh  <= sh >> 1;
            idx <= idx + IW'(1);
            if (idx == IW'(BYTE_W - 1)) phase <= TX_OFF;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign pull_low = (phase == TX_SEND) && (cnt < (sh[0] ? CW'(LOW_ONE) : CW'(LOW_ZERO)));
  assign busy     = (phase != TX_OFF);
endmodule

// File: rtl/sw_link_slave.sv
module sw_link_slave
  import sw_link_pkg::*;
#(
  parameter int SAMPLE_AT    = 20,
  parameter int BREAK_MIN    = 60,
  parameter int RESP_DELAY   = 40,
  parameter int BIT_CELL     = 50,
  parameter int TX_LOW_ONE   = 8,
  parameter int TX_LOW_ZERO  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_in,
  output logic       line_pull_low,
  output logic [6:0] reg_addr,
  output logic       reg_wr_en,
  output logic [7:0] reg_wr_data,
  output logic       reg_rd_en,
  input  logic [7:0] reg_rd_data
);
  localparam int IW = $clog2(BYTE_W);

  logic line_s, fall, brk_evt, bit_stb, bit_val, tx_busy, tx_active;
  link_state_e       state;
  logic [BYTE_W-1:0] sh, sh_n;
  logic [IW-1:0]     idx;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] wdata_q;
  logic              wr_q;
  logic              last_bit;

  sw_line_sync #(.BREAK_MIN(BREAK_MIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_in(line_in),
    .line_s(line_s), .fall(fall), .brk_evt(brk_evt)
  );

  sw_bit_rx #(.SAMPLE_AT(SAMPLE_AT)) u_rx (
    .clk(clk), .rst_n(rst_n), .line_s(line_s), .fall(fall),
    .bit_stb(bit_stb), .bit_val(bit_val)
  );

  sw_bit_tx #(
    .RESP_DELAY(RESP_DELAY), .BIT_CELL(BIT_CELL),
    .LOW_ONE(TX_LOW_ONE), .LOW_ZERO(TX_LOW_ZERO)
  ) u_tx (
    .clk(clk), .rst_n(rst_n),
    .start(state == ST_RDREQ), .abort(brk_evt), .byte_in(reg_rd_data),
    .pull_low(line_pull_low), .busy(tx_busy)
  );

  assign sh_n      = shift_in(sh, bit_val);
  assign last_bit  = (idx == IW'(BYTE_W - 1));
  assign tx_active = (state == ST_TX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sh      <= '0;
      idx     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      if (brk_evt) begin
        state <= ST_CMD;
        idx   <= '0;
      end else begin
        case (state)
          ST_CMD: if (bit_stb) begin
            sh  <= sh_n;
            idx <= idx + IW'(1);
            if (last_bit) begin
              addr_q <= cmd_addr(sh_n);
              state  <= cmd_is_write(sh_n) ? ST_DATA : ST_RDREQ;
            end
          end
          ST_DATA: if (bit_stb) begin
            sh  <= sh_n;
            idx <= idx + IW'(1);
            if (last_bit) begin
              wdata_q <= sh_n;
              wr_q    <= 1'b1;
              state   <= ST_IDLE;
            end
          end
          ST_RDREQ: state <= ST_TX;
          ST_TX:    if (!tx_busy) state <= ST_IDLE;
          default: ;
        endcase
      end
    end
  end

  assign reg_addr    = addr_q;
  assign reg_wr_en   = wr_q;
  assign reg_wr_data = wdata_q;
  assign reg_rd_en   = (state == ST_RDREQ);
endmodule

// File: rtl/sw_link_slave_chk.sv
module sw_link_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       line_pull_low,
  input logic       reg_wr_en,
  input logic       reg_rd_en,
  input logic       brk_evt,
  input logic       tx_active,
  input logic [6:0] reg_addr
);
  // R4: write strobe lasts one cycle
  a_r4_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

  // R5: read strobe lasts one cycle and the address holds across it
  a_r5_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> !reg_rd_en);
  a_r5_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> $stable(reg_addr));

  // R6: the pull-down is only requested during a response
  a_r6_pull_in_reply: assert property (@(posedge clk) disable iff (!rst_n)
    line_pull_low |-> tx_active);

  // R8: a break releases the wire and suppresses a pending write
  a_r8_break_release: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> !line_pull_low);
  a_r8_break_no_wr: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> !reg_wr_en);

  // R9: one transaction per frame, never both strobes together
  a_r9_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_rd_en));
endmodule

bind sw_link_slave sw_link_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .line_pull_low(line_pull_low),
  .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .brk_evt(brk_evt),
  .tx_active(tx_active), .reg_addr(reg_addr)
);

// File: tb/sim_sw_link_slave.sv
`timescale 1ns/1ps
module sim_sw_link_slave;
  localparam int SAMPLE_AT = 20;
  localparam int BREAK_MIN = 60;
  localparam int RESP_DELAY = 40;
  localparam int BIT_CELL = 50;
  localparam int LOW_ONE = 8;
  localparam int LOW_ZERO = 32;
  localparam int H_ONE = 8;
  localparam int H_ZERO = 35;
  localparam int H_CELL = 60;
  localparam int H_BREAK = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_low = 1'b0;
  logic line_pull_low, reg_wr_en, reg_rd_en;
  logic [6:0] reg_addr;
  logic [7:0] reg_wr_data, reg_rd_data;
  logic [7:0] mem [128];
  int cyc = 0, checks = 0, errors = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [6:0] wr_addr_seen, rd_addr_seen;
  logic [7:0] wr_data_seen;

  always #10 clk = ~clk;

  sw_link_slave #(
    .SAMPLE_AT(SAMPLE_AT), .BREAK_MIN(BREAK_MIN), .RESP_DELAY(RESP_DELAY),
    .BIT_CELL(BIT_CELL), .TX_LOW_ONE(LOW_ONE), .TX_LOW_ZERO(LOW_ZERO)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .line_in(~(host_low | line_pull_low)),
    .line_pull_low(line_pull_low), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data)
  );

  assign reg_rd_data = mem[reg_addr];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (reg_wr_en) begin
      wr_cnt <= wr_cnt + 1;
      wr_addr_seen <= reg_addr;
      wr_data_seen <= reg_wr_data;
      mem[reg_addr] <= reg_wr_data;
    end
    if (reg_rd_en) begin
      rd_cnt <= rd_cnt + 1;
      rd_addr_seen <= reg_addr;
    end
    if (cyc > 150000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk) host_low = 1'b1;
    idle(b ? H_ONE : H_ZERO);
    host_low = 1'b0;
    idle(H_CELL - (b ? H_ONE : H_ZERO));
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic send_break();
    @(negedge clk) host_low = 1'b1;
    idle(H_BREAK);
    host_low = 1'b0;
    idle(20);
  endtask

  function automatic int count_pull(input int n);
    return n;
  endfunction

  task automatic watch_quiet(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (line_pull_low) highs++;
    end
  endtask

  task automatic t_reset();
    idle(3);
    chk(line_pull_low == 1'b0, "R10 pull", line_pull_low, 0);
    chk(reg_wr_en == 1'b0, "R10 wr", reg_wr_en, 0);
    chk(reg_rd_en == 1'b0, "R10 rd", reg_rd_en, 0);
  endtask

  task automatic t_before_break();
    int hi;
    send_byte(8'h85);
    send_byte(8'h11);
    send_byte(8'h05);
    watch_quiet(300, hi);
    chk(wr_cnt == 0 && rd_cnt == 0, "R1 no strobe before break", wr_cnt + rd_cnt, 0);
    chk(hi == 0, "R1 no reply before break", hi, 0);
  endtask

  task automatic t_write(input logic [6:0] a, input logic [7:0] d);
    int w0 = wr_cnt, r0 = rd_cnt;
    send_break();
    send_byte({1'b1, a});
    send_byte(d);
    idle(10);
    chk(wr_cnt == w0 + 1, "R4 one write strobe", wr_cnt - w0, 1);
    chk(wr_addr_seen == a, "R2 write address", wr_addr_seen, a);
    chk(wr_data_seen == d, "R3 write data", wr_data_seen, d);
    chk(rd_cnt == r0, "R2 write flag gives no read", rd_cnt - r0, 0);
  endtask

  task automatic t_read(input logic [6:0] a);
    logic [7:0] cmd = {1'b0, a};
    logic [7:0] exp = mem[a];
    int r0 = rd_cnt, t_fall, t_prev, n, wait_n;
    send_break();
    for (int i = 0; i < 7; i++) send_bit(cmd[i]);
    @(negedge clk) host_low = 1'b1;
    t_fall = cyc;
    idle(H_ZERO);
    host_low = 1'b0;
    wait_n = 0;
    while (!line_pull_low && wait_n < 400) begin @(negedge clk); wait_n++; end
    chk((cyc - t_fall) >= SAMPLE_AT + RESP_DELAY && (cyc - t_fall) <= SAMPLE_AT + RESP_DELAY + 8,
        "R7 response delay", cyc - t_fall, SAMPLE_AT + RESP_DELAY + 5);
    chk(rd_cnt == r0 + 1, "R5 one read strobe", rd_cnt - r0, 1);
    chk(rd_addr_seen == a, "R5 read address", rd_addr_seen, a);
    t_prev = cyc;
    for (int i = 0; i < 8; i++) begin
      if (i > 0) begin
        wait_n = 0;
        while (!line_pull_low && wait_n < 200) begin @(negedge clk); wait_n++; end
        chk(cyc - t_prev == BIT_CELL, "R6 cell spacing", cyc - t_prev, BIT_CELL);
        t_prev = cyc;
      end
      n = 0;
      while (line_pull_low && n < 200) begin @(negedge clk); n++; end
      chk(n == (exp[i] ? LOW_ONE : LOW_ZERO), "R6 pulse width", n, exp[i] ? LOW_ONE : LOW_ZERO);
    end
    idle(60);
  endtask

  task automatic t_after_done();
    int hi, w0 = wr_cnt, r0 = rd_cnt;
    send_byte(8'h05);
    send_byte(8'h9A);
    send_byte(8'h33);
    watch_quiet(300, hi);
    chk(wr_cnt == w0 && rd_cnt == r0, "R9 no strobe after frame end", wr_cnt - w0 + rd_cnt - r0, 0);
    chk(hi == 0, "R9 no reply after frame end", hi, 0);
  endtask

  task automatic t_abort();
    int hi, wait_n = 0, r0 = rd_cnt;
    send_break();
    send_byte({1'b0, 7'h12});
    while (!line_pull_low && wait_n < 400) begin @(negedge clk); wait_n++; end
    chk(line_pull_low == 1'b1, "R8 reply started", line_pull_low, 1);
    send_break();
    watch_quiet(600, hi);
    chk(hi == 0, "R8 reply aborted by break", hi, 0);
    chk(rd_cnt == r0 + 1, "R8 single read before abort", rd_cnt - r0, 1);
    t_write(7'h2A, 8'hC3);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 8'(i * 37 + 11);
    idle(4);
    rst_n = 1'b1;
    t_reset();
    t_before_break();
    t_write(7'h12, 8'h3C);
    t_after_done();
    t_write(7'h7F, 8'hFF);
    t_write(7'h00, 8'h00);
    t_read(7'h12);
    t_read(7'h7F);
    t_read(7'h00);
    t_read(7'h55);
    t_abort();
    t_read(7'h2A);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule